// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests from on-chip peripheral sources and from four external request pins. It merges them into one normal processor request line, and it passes a dedicated external fast-interrupt pin to a separate fast request line. Each normal source has its own configuration: a mask bit, a 3-bit priority (eight levels, 7 highest), a trigger mode and a vector value. A priority encoder picks the best pending, unmasked source. The encoder's result is registered, and its vector is shown on the vector output while the normal request is high.

The processor services a request by pulsing `vec_rd_i` while it reads `vec_o`. That read acknowledges the selected source: its edge latch is cleared and its priority level is marked as in service. While any levels are in service, only a source whose priority is strictly above the highest in-service level is forwarded. An end-of-interrupt pulse on `eoi_i` releases the highest in-service level, so nested handlers unwind in order.

Source numbering: internal sources take indices 0 to N_INT-1 (pins `int_src_i[i]`). External sources take indices N_INT to N_INT+N_EXT-1 (pins `ext_src_i[i-N_INT]`). With the defaults there are 12 sources, indices 0 to 11.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset, `irq_o` and `fiq_o` are low, `vec_o` equals the spurious value SPUR_VEC (default 8'hFF), and every source is masked with mode 2'b00, priority 0 and vector 0.
- R2: `fiq_o` equals the value of `fiq_pin_i` one clock earlier. No normal source, mask, acknowledge or end-of-interrupt affects it.
- R3: A masked source (mask bit 1) never raises `irq_o`. An edge that arrives while the source is masked is still latched, and it is forwarded once the source is unmasked.
- R4: For an internal source, mode bit 0 selects the trigger: 1 latches a rising edge, 0 is active-high level. Mode bit 1 is ignored for internal sources.
- R5: For an external source, the mode is 2'b00 low level, 2'b01 high level, 2'b10 falling edge, 2'b11 rising edge (bit 1 = edge, bit 0 = high/rising).
- R6: Among pending unmasked sources, the one with the numerically highest priority is selected. On equal priorities, the lower source index wins.
- R7: While `irq_o` is high, `vec_o` shows the configured vector of the selected source. While `irq_o` is low, `vec_o` shows SPUR_VEC.
- R8: A `vec_rd_i` pulse while `irq_o` is high clears the selected source's edge latch and marks its priority level in service. `irq_o` then drops in the next cycle unless a source of strictly higher priority is pending.
- R9: While levels are in service, a pending source is forwarded only if its priority is strictly greater than the highest in-service level.
- R10: An `eoi_i` pulse releases the highest in-service level. `eoi_i` with nothing in service, and `vec_rd_i` while `irq_o` is low, change no state.
- R11: A source condition that is present before a clock edge is reflected on `irq_o` immediately after that edge: one register stage from pin to request.
- R12: A configuration write with `cfg_idx_i` at or above the number of sources changes no source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_src_i | input | N_INT | Internal peripheral request lines |
| ext_src_i | input | N_EXT | External request pins |
| fiq_pin_i | input | 1 | Dedicated fast-interrupt pin |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | IDX_W | Source index being written |
| cfg_mask_i | input | 1 | Mask bit to write (1 = masked) |
| cfg_prio_i | input | 3 | Priority to write |
| cfg_mode_i | input | 2 | Trigger mode to write |
| cfg_vec_i | input | VEC_W | Vector to write |
| vec_rd_i | input | 1 | Vector read / acknowledge pulse |
| eoi_i | input | 1 | End-of-interrupt pulse |
| irq_o | output | 1 | Normal processor request |
| fiq_o | output | 1 | Fast processor request |
| vec_o | output | VEC_W | Vector of the selected source or SPUR_VEC |

## Verification
A wrong edge latch or mode decode shows at the ports within one cycle: `irq_o` rises where it should not, or stays low where it should rise. A corrupted in-service level set stays hidden until a later source of nearby priority arrives. At that point the wrong forwarding decision shows up as an extra or missing request, and an end-of-interrupt sequence exposes it one level at a time. The bench compares `irq_o`, `vec_o` and `fiq_o` against a behavioural model on every clock. Its directed sequences walk each trigger mode, tie-breaking, nesting and unwind, so a divergence is caught in the cycle it first reaches a port.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int PRIO_W = 3;
    localparam int N_LVL  = 1 << PRIO_W;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [1:0]        trig_t;
endpackage

// File: rtl/intc_src_cell.sv
module intc_src_cell
    import intc_pkg::*;
#(
    parameter bit IS_EXT = 1'b0,
    parameter int VEC_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_i,
    input  logic             cfg_we_i,
    input  logic             cfg_mask_i,
    input  prio_t            cfg_prio_i,
    input  trig_t            cfg_mode_i,
    input  logic [VEC_W-1:0] cfg_vec_i,
    input  logic             ack_i,
    output logic             req_o,
    output prio_t            prio_o,
    output logic [VEC_W-1:0] vec_o
);
    typedef struct packed {
        logic             masked;
        prio_t            prio;
        trig_t            mode;
        logic [VEC_W-1:0] vec;
        logic             prev;
        logic             latch;
    } cell_t;

    localparam cell_t CELL_RST = cell_t'({1'b1, {($bits(cell_t)-1){1'b0}}});

    cell_t s_q, s_d;
    logic  is_edge;
    logic  pol;
    logic  edge_det;

    always_comb begin
        s_d      = s_q;
        // external: bit1 = edge, bit0 = polarity; internal: bit0 = edge, high only
        is_edge  = IS_EXT ? s_q.mode[1] : s_q.mode[0];
        pol      = IS_EXT ? s_q.mode[0] : 1'b1;
        edge_det = is_edge && (pol ? (pin_i && !s_q.prev) : (!pin_i && s_q.prev));

        if (edge_det) begin
            s_d.latch = 1'b1;
        end else if (ack_i) begin
            s_d.latch = 1'b0;
        end
        s_d.prev = pin_i;

        if (cfg_we_i) begin
            s_d.masked = cfg_mask_i;
            s_d.prio   = cfg_prio_i;
            s_d.mode   = cfg_mode_i;
            s_d.vec    = cfg_vec_i;
        end

        req_o  = !s_q.masked && (is_edge ? s_d.latch : (pin_i == pol));
        prio_o = s_q.prio;
        vec_o  = s_q.vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= CELL_RST;
        end else begin
            s_q <= s_d;
        end
    end

    AST_LATCH_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (is_edge && s_q.latch && !ack_i) |=> s_q.latch); // R4
endmodule

// File: rtl/intc_prio_enc.sv
module intc_prio_enc
    import intc_pkg::*;
#(
    parameter int N     = 12,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     req_i,
    input  prio_t            prio_i [N],
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o,
    output prio_t            prio_o
);
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        prio_o  = '0;
        // ascending scan with strict compare: lower index keeps ties
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && (!valid_o || prio_i[i] > prio_o)) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(i);
                prio_o  = prio_i[i];
            end
        end
    end
endmodule

// File: rtl/intc_nest.sv
module intc_nest
    import intc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push_i,
    input  prio_t push_lvl_i,
    input  logic  pop_i,
    output logic  busy_o,
    output prio_t top_o
);
    logic [N_LVL-1:0] isr_q, isr_d;

    function automatic prio_t top_of(input logic [N_LVL-1:0] m);
        prio_t t;
        t = '0;
        for (int l = 0; l < N_LVL; l++) begin
            if (m[l]) t = prio_t'(l);
        end
        return t;
    endfunction

    always_comb begin
        isr_d = isr_q;
        if (pop_i && (isr_q != '0)) begin
            isr_d[top_of(isr_q)] = 1'b0;
        end
        if (push_i) begin
            isr_d[push_lvl_i] = 1'b1;
        end
        busy_o = (isr_d != '0);
        top_o  = top_of(isr_d);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            isr_q <= '0;
        end else begin
            isr_q <= isr_d;
        end
    end

    AST_PUSH_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && (isr_q != '0)) |-> (push_lvl_i > top_of(isr_q))); // R9
    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i) |=> ($countones(isr_q) == $past($countones(isr_q)) + 1)); // R8
    AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && (isr_q != '0)) |=> ($countones(isr_q) == $past($countones(isr_q)) - 1)); // R10
    AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && (isr_q == '0)) |=> (isr_q == '0)); // R10
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
    import intc_pkg::*;
#(
    parameter int               N_INT    = 8,
    parameter int               N_EXT    = 4,
    parameter int               VEC_W    = 8,
    parameter logic [VEC_W-1:0] SPUR_VEC = '1,
    localparam int              N_SRC    = N_INT + N_EXT,
    localparam int              IDX_W    = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_INT-1:0] int_src_i,
    input  logic [N_EXT-1:0] ext_src_i,
    input  logic             fiq_pin_i,
    input  logic             cfg_we_i,
    input  logic [IDX_W-1:0] cfg_idx_i,
    input  logic             cfg_mask_i,
    input  logic [2:0]       cfg_prio_i,
    input  logic [1:0]       cfg_mode_i,
    input  logic [VEC_W-1:0] cfg_vec_i,
    input  logic             vec_rd_i,
    input  logic             eoi_i,
    output logic             irq_o,
    output logic             fiq_o,
    output logic [VEC_W-1:0] vec_o
);
    typedef struct packed {
        logic             irq;
        logic             fiq;
        logic [IDX_W-1:0] sel;
        prio_t            prio;
        logic [VEC_W-1:0] vec;
    } top_t;

    top_t s_q, s_d;

    logic [N_SRC-1:0] pins;
    logic [N_SRC-1:0] req;
    logic [N_SRC-1:0] ack_vec;
    prio_t            prio_a [N_SRC];
    logic [VEC_W-1:0] vec_a  [N_SRC];
    logic             ack;
    logic             enc_valid;
    logic [IDX_W-1:0] enc_idx;
    prio_t            enc_prio;
    logic             nest_busy;
    prio_t            nest_top;
    logic             fwd;

    assign pins = {ext_src_i, int_src_i};
    assign ack  = vec_rd_i && s_q.irq;

    always_comb begin
        ack_vec = '0;
        if (ack) ack_vec[s_q.sel] = 1'b1;
    end

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        intc_src_cell #(
            .IS_EXT (g >= N_INT),
            .VEC_W  (VEC_W)
        ) u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin_i      (pins[g]),
            .cfg_we_i   (cfg_we_i && (cfg_idx_i == IDX_W'(g))),
            .cfg_mask_i (cfg_mask_i),
            .cfg_prio_i (cfg_prio_i),
            .cfg_mode_i (cfg_mode_i),
            .cfg_vec_i  (cfg_vec_i),
            .ack_i      (ack_vec[g]),
            .req_o      (req[g]),
            .prio_o     (prio_a[g]),
            .vec_o      (vec_a[g])
        );
    end

    intc_prio_enc #(
        .N     (N_SRC),
        .IDX_W (IDX_W)
    ) u_enc (
        .req_i   (req),
        .prio_i  (prio_a),
        .valid_o (enc_valid),
        .idx_o   (enc_idx),
        .prio_o  (enc_prio)
    );

    intc_nest u_nest (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (ack),
        .push_lvl_i (s_q.prio),
        .pop_i      (eoi_i),
        .busy_o     (nest_busy),
        .top_o      (nest_top)
    );

    always_comb begin
        s_d      = s_q;
        fwd      = enc_valid && (!nest_busy || (enc_prio > nest_top));
        s_d.fiq  = fiq_pin_i;
        s_d.irq  = fwd;
        s_d.sel  = enc_idx;
        s_d.prio = enc_prio;
        s_d.vec  = vec_a[enc_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign irq_o = s_q.irq;
    assign fiq_o = s_q.fiq;
    assign vec_o = s_q.irq ? s_q.vec : SPUR_VEC;

    AST_FIQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_pin_i |=> fiq_o); // R2
    AST_FIQ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        !fiq_pin_i |=> !fiq_o); // R2
    AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd_i && irq_o) |=> (!irq_o || (s_q.prio > $past(s_q.prio)))); // R8
    AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd_i && !irq_o && !eoi_i) |-> (ack_vec == '0)); // R10
endmodule

// File: tb/prio_vec_intc_bench.sv
`timescale 1ns/1ps
module prio_vec_intc_bench;
    localparam int NI = 8;
    localparam int NE = 4;
    localparam int NS = NI + NE;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [NI-1:0] int_src = '0;
    logic [NE-1:0] ext_src = '0;
    logic       fiq_pin = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_idx = '0;
    logic       cfg_mask = 1'b0;
    logic [2:0] cfg_prio = '0;
    logic [1:0] cfg_mode = '0;
    logic [7:0] cfg_vec = '0;
    logic       vec_rd = 1'b0;
    logic       eoi = 1'b0;
    logic       irq_o, fiq_o;
    logic [7:0] vec_o;

    int n_chk = 0;
    int n_fail = 0;
    string cur_tag = "R1";

    always #10 clk = ~clk;

    prio_vec_intc u_prio_vec_intc (
        .clk(clk), .rst_n(rst_n), .int_src_i(int_src), .ext_src_i(ext_src),
        .fiq_pin_i(fiq_pin), .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx),
        .cfg_mask_i(cfg_mask), .cfg_prio_i(cfg_prio), .cfg_mode_i(cfg_mode),
        .cfg_vec_i(cfg_vec), .vec_rd_i(vec_rd), .eoi_i(eoi),
        .irq_o(irq_o), .fiq_o(fiq_o), .vec_o(vec_o)
    );

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit       m_mask [NS];
    int       m_prio [NS];
    bit [1:0] m_mode [NS];
    int       m_vec  [NS];
    bit       m_prev [NS];
    bit       m_latch[NS];
    bit [7:0] m_isr;
    bit       m_irq, m_fiq;
    int       m_sel, m_selprio, m_vecr;

    function automatic int top_lvl(bit [7:0] m);
        int t = -1;
        for (int l = 0; l < 8; l++) if (m[l]) t = l;
        return t;
    endfunction

    always @(posedge clk) begin : mdl
        bit [NS-1:0] pins;
        bit          nl [NS];
        bit          pend [NS];
        bit          ack, edg, pol, det;
        bit [7:0]    isr_n;
        int          best, bestp, t;
        if (!rst_n) begin
            for (int i = 0; i < NS; i++) begin
                m_mask[i] = 1'b1; m_prio[i] = 0; m_mode[i] = 2'b00; m_vec[i] = 0;
                m_prev[i] = 1'b0; m_latch[i] = 1'b0;
            end
            m_isr = '0; m_irq = 1'b0; m_fiq = 1'b0; m_sel = 0; m_selprio = 0; m_vecr = 0;
        end else begin
            pins = {ext_src, int_src};
            ack  = vec_rd && m_irq;
            for (int i = 0; i < NS; i++) begin
                edg = (i >= NI) ? m_mode[i][1] : m_mode[i][0];
                pol = (i >= NI) ? m_mode[i][0] : 1'b1;
                det = edg && (pol ? (pins[i] && !m_prev[i]) : (!pins[i] && m_prev[i]));
                nl[i] = det ? 1'b1 : ((ack && m_sel == i) ? 1'b0 : m_latch[i]);
                pend[i] = !m_mask[i] && (edg ? nl[i] : (pins[i] == pol));
            end
            isr_n = m_isr;
            if (eoi && isr_n != 0) isr_n[top_lvl(isr_n)] = 1'b0;
            if (ack) isr_n[m_selprio] = 1'b1;
            best = -1; bestp = -1;
            for (int i = 0; i < NS; i++)
                if (pend[i] && m_prio[i] > bestp) begin best = i; bestp = m_prio[i]; end
            t = top_lvl(isr_n);
            m_irq = (best >= 0) && (bestp > t);
            if (m_irq) begin m_sel = best; m_selprio = bestp; m_vecr = m_vec[best]; end
            m_fiq = fiq_pin;
            m_isr = isr_n;
            for (int i = 0; i < NS; i++) begin m_prev[i] = pins[i]; m_latch[i] = nl[i]; end
            if (cfg_we && cfg_idx < NS) begin
                m_mask[cfg_idx] = cfg_mask; m_prio[cfg_idx] = cfg_prio;
                m_mode[cfg_idx] = cfg_mode; m_vec[cfg_idx] = cfg_vec;
            end
            #5;
            chk(cur_tag, "model irq", irq_o, m_irq);
            chk(cur_tag, "model vec", vec_o, m_irq ? m_vecr : 8'hFF);
            chk("R2", "model fiq", fiq_o, m_fiq);
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic cfg(int idx, bit mk, int pr, bit [1:0] md, int vc);
        cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_mask = mk;
        cfg_prio = 3'(pr); cfg_mode = md; cfg_vec = 8'(vc);
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic rd();  vec_rd = 1'b1; tick(); vec_rd = 1'b0; endtask
    task automatic done(); eoi = 1'b1;   tick(); eoi = 1'b0;    endtask

    initial begin
        repeat (3) tick();
        chk("R1", "irq in reset", irq_o, 0);
        chk("R1", "vec in reset", vec_o, 8'hFF);
        chk("R1", "fiq in reset", fiq_o, 0);
        rst_n = 1'b1;

        // R1/R3: all sources masked after reset
        cur_tag = "R3"; int_src = '1; ext_src = '0;
        repeat (3) tick();
        chk("R3", "masked after reset", irq_o, 0);
        int_src = '0; ext_src = '1; tick();

        // R2 fast pin
        cur_tag = "R2"; fiq_pin = 1'b1; tick();
        chk("R2", "fiq set", fiq_o, 1);
        fiq_pin = 1'b0; tick();
        chk("R2", "fiq clear", fiq_o, 0);

        // R4 internal level, R11 latency, R7 vector, R8 ack, R10 eoi
        cur_tag = "R4"; cfg(0, 0, 2, 2'b00, 8'h10);
        int_src[0] = 1'b1; tick();
        chk("R11", "irq one cycle after level", irq_o, 1);
        chk("R7", "vector of selected", vec_o, 8'h10);
        cur_tag = "R8"; rd();
        chk("R8", "irq drops after read", irq_o, 0);
        cur_tag = "R10"; done();
        chk("R10", "eoi re-forwards held level", irq_o, 1);
        int_src[0] = 1'b0; tick();
        chk("R4", "level released", irq_o, 0);

        // R4 internal edge; mode bit1 ignored
        cur_tag = "R4"; cfg(1, 0, 4, 2'b11, 8'h21);
        int_src[1] = 1'b1; tick();
        chk("R4", "rising edge", vec_o, 8'h21);
        int_src[1] = 1'b0; tick();
        chk("R4", "edge stays latched", irq_o, 1);
        rd();
        chk("R8", "latch cleared by read", irq_o, 0);
        done();
        chk("R8", "no re-forward after eoi", irq_o, 0);
        cfg(2, 0, 1, 2'b10, 8'h22);
        int_src[2] = 1'b1; tick();
        chk("R4", "mode 10 internal is level", vec_o, 8'h22);
        int_src[2] = 1'b0; tick();
        chk("R4", "mode 10 internal level off", irq_o, 0);

        // R5 external modes
        cur_tag = "R5"; cfg(8, 0, 3, 2'b00, 8'h30);
        ext_src[0] = 1'b0; tick();
        chk("R5", "low level", vec_o, 8'h30);
        ext_src[0] = 1'b1; tick();
        chk("R5", "low level off", irq_o, 0);
        cfg(9, 0, 3, 2'b01, 8'h31); tick();
        chk("R5", "high level", vec_o, 8'h31);
        ext_src[1] = 1'b0; tick();
        chk("R5", "high level off", irq_o, 0);
        cfg(10, 0, 3, 2'b10, 8'h32);
        ext_src[2] = 1'b0; tick();
        chk("R5", "falling edge", vec_o, 8'h32);
        ext_src[2] = 1'b1; tick();
        chk("R5", "falling edge latched", irq_o, 1);
        rd(); done();
        chk("R5", "falling served", irq_o, 0);
        cfg(11, 0, 3, 2'b11, 8'h33);
        ext_src[3] = 1'b0; tick();
        chk("R5", "rising ignores fall", irq_o, 0);
        ext_src[3] = 1'b1; tick();
        chk("R5", "rising edge", vec_o, 8'h33);
        rd(); done();

        // R6 tie, R9 nesting, R10 unwind
        cur_tag = "R6";
        cfg(3, 0, 5, 2'b01, 8'h43);
        cfg(4, 0, 5, 2'b01, 8'h44);
        cfg(5, 0, 6, 2'b01, 8'h45);
        int_src[3] = 1'b1; int_src[4] = 1'b1; fiq_pin = 1'b1; tick();
        chk("R6", "tie to lower index", vec_o, 8'h43);
        int_src[3] = 1'b0; int_src[4] = 1'b0; fiq_pin = 1'b0;
        cur_tag = "R9"; rd();
        chk("R9", "equal priority held off", irq_o, 0);
        int_src[5] = 1'b1; tick();
        chk("R9", "higher priority nests", vec_o, 8'h45);
        int_src[5] = 1'b0; rd();
        chk("R9", "after nested read", irq_o, 0);
        cur_tag = "R10"; done();
        chk("R10", "one level released", irq_o, 0);
        done();
        chk("R10", "all released, waiting source", vec_o, 8'h44);
        rd(); done();

        // R3 masked edge remembered
        cur_tag = "R3"; cfg(6, 1, 7, 2'b01, 8'h56);
        int_src[6] = 1'b1; tick();
        int_src[6] = 1'b0; tick();
        chk("R3", "masked edge not forwarded", irq_o, 0);
        cfg(6, 0, 7, 2'b01, 8'h56); tick();
        chk("R3", "latched edge after unmask", vec_o, 8'h56);
        rd(); done();

        // R10 no-effect cases
        cur_tag = "R10"; int_src[0] = 1'b1; tick();
        done();
        chk("R10", "eoi with empty stack", vec_o, 8'h10);
        int_src[0] = 1'b0; tick();
        rd();
        int_src[0] = 1'b1; tick();
        chk("R10", "idle read left no level", vec_o, 8'h10);
        rd(); done();
        int_src[0] = 1'b0; tick();

        // R12 out-of-range index
        cur_tag = "R12"; cfg(12, 1, 0, 2'b00, 8'h99);
        int_src[0] = 1'b1; tick();
        chk("R12", "source 0 untouched", vec_o, 8'h10);
        int_src[0] = 1'b0; tick(); tick();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule